// File: doc/BRIEF.md
# I/O Address Translation and Protection Unit

This unit sits between I/O devices and the memory system. It turns the I/O address of each device request into a real address and decides whether the access is allowed. Each request carries an I/O address, the ID of the requesting device and a read/write flag.

The top bits of the I/O address select a segment. The segment register says whether the segment is valid and which of four page sizes it uses. The page size fixes where the remaining address bits split into a page number and a page offset. The page number is then looked up in a small, fully associative translation cache. A hit returns the page's real frame, its read and write permissions, the device ID it belongs to and its command-ordering attribute.

A miss either fails at once or, when hardware loading is enabled, sends a fetch to an external table walker and holds the request until the walker answers. Software can program segment registers, write cache entries directly and flush the whole cache. Each protection violation is latched in a fault status register.

Top module: `io_xlate_unit`

## Requirements
- R1: The segment index is I/O address bits [IOA_W-1:SEG_OFF_W]. A request to a segment whose valid bit is clear gets a translation fault (fault code 1, ok=0) and never starts a walk.
- R2: Page-size code 0, 1, 2 and 3 gives a page offset of 12, 16, 20 and 24 bits. The page number is the segment offset shifted right by that width. The real address takes its offset bits from the I/O address and all higher bits from the entry's real frame number, which holds real address bits [RA_W-1:12].
- R3: A permitted cache hit returns ok=1, fault code 0, the translated address and the entry's ordering attribute.
- R4: A write to a page with its write permission clear, or a read from a page with its read permission clear, is denied. The response carries protection fault code 2, ok=0, and a real address and ordering attribute of zero.
- R5: A request whose device ID differs from the device ID of the matching entry is denied with protection fault code 2, even when the page permits the access type.
- R6: Every denied protection access sets flt_valid and latches the request's I/O address and device ID. A later violation overwrites them. flt_clr clears flt_valid. Successful or translation-faulted requests leave the status unchanged.
- R7: When cfg_hw_load=1, a miss in a valid segment drives wlk_req_valid for exactly one cycle, carrying the segment index and page number. req_ready stays low until the walker answers. A clean answer fills a cache entry, and the request then completes from that entry without a second fetch.
- R8: A walker answer with wlk_rsp_err=1 completes the stalled request with translation fault code 1 and fills no entry.
- R9: When cfg_hw_load=0, a miss in a valid segment completes with translation fault code 1 and issues no walker request.
- R10: A software cache write to index sw_tc_idx takes effect for lookups in the next cycle. It replaces any earlier contents of that entry.
- R11: sw_inval clears the valid bit of every cache entry in one cycle, so that the next lookup misses. It overrides a software write or walker fill in the same cycle.
- R12: Each accepted request (req_valid and req_ready high at a clock edge) produces exactly one rsp_valid pulse, in the following cycle. No response appears without an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hw_load | input | 1 | Enables walker fetch on a cache miss |
| req_valid | input | 1 | Request present; must be held until accepted |
| req_ready | output | 1 | Request accepted this cycle |
| req_ioa | input | IOA_W | I/O address |
| req_dev | input | DEV_W | Requesting device ID |
| req_wr | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Access permitted |
| rsp_fault | output | 2 | 0 none, 1 translation, 2 protection |
| rsp_ra | output | RA_W | Real address (zero when denied) |
| rsp_ord | output | ORD_W | Ordering attribute of the page |
| wlk_req_valid | output | 1 | Walker fetch pulse |
| wlk_req_seg | output | SEG_IDX_W | Segment index to fetch |
| wlk_req_vpn | output | VPN_W | Page number to fetch |
| wlk_rsp_valid | input | 1 | Walker answer |
| wlk_rsp_err | input | 1 | Walker found no valid page |
| wlk_rsp_rpn | input | RPN_W | Real frame number |
| wlk_rsp_rd | input | 1 | Read permitted |
| wlk_rsp_wr | input | 1 | Write permitted |
| wlk_rsp_dev | input | DEV_W | Owning device ID |
| wlk_rsp_ord | input | ORD_W | Ordering attribute |
| sw_seg_we | input | 1 | Segment register write |
| sw_seg_idx | input | SEG_IDX_W | Segment register index |
| sw_seg_valid | input | 1 | Segment valid bit |
| sw_seg_psz | input | 2 | Page-size code |
| sw_tc_we | input | 1 | Cache entry write |
| sw_tc_idx | input | TC_IDX_W | Cache entry index |
| sw_tc_seg | input | SEG_IDX_W | Entry segment tag |
| sw_tc_vpn | input | VPN_W | Entry page number tag |
| sw_tc_rpn | input | RPN_W | Entry real frame number |
| sw_tc_rd | input | 1 | Entry read permission |
| sw_tc_wr | input | 1 | Entry write permission |
| sw_tc_dev | input | DEV_W | Entry device ID |
| sw_tc_ord | input | ORD_W | Entry ordering attribute |
| sw_inval | input | 1 | Flush all cache entries |
| flt_clr | input | 1 | Clear fault status |
| flt_valid | output | 1 | Protection fault recorded |
| flt_ioa | output | IOA_W | Faulting I/O address |
| flt_dev | output | DEV_W | Faulting device ID |

## Verification
The bench builds the unit with its default parameters: a 32-bit I/O address, a 28-bit segment offset, a 32-bit real address and four cache entries. A 28-bit segment offset leaves room for all four page sizes, so the bench translates one page of each size and checks the split point of each. It can then lay a permission denial and a device mismatch over separately placed entries. With four entries and a bench walker that answers three cycles after a fetch, both walker outcomes and the stall they cause can be reached, alongside flush and software rewrite of individual entries.

// File: rtl/iox_pkg.sv
package iox_pkg;

   typedef enum logic [1:0] {
      PSZ_4K  = 2'd0,
      PSZ_64K = 2'd1,
      PSZ_1M  = 2'd2,
      PSZ_16M = 2'd3
   } iox_psz_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_XLATE = 2'd1,
      FLT_PROT  = 2'd2
   } iox_flt_e;

   typedef enum logic [1:0] {
      ST_LOOK  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WAIT  = 2'd2
   } iox_state_e;

   localparam int MIN_PAGE_W = 12;

endpackage

// File: rtl/iox_seg_table.sv
module iox_seg_table #(
   parameter int SEG_IDX_W = 4,
   localparam int SEG_N = 1 << SEG_IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [SEG_IDX_W-1:0] widx,
   input  logic                 wvalid,
   input  logic [1:0]           wpsz,
   input  logic [SEG_IDX_W-1:0] ridx,
   output logic                 rvalid,
   output logic [1:0]           rpsz
);

   logic       vld_q [SEG_N];
   logic [1:0] psz_q [SEG_N];

   for (genvar g = 0; g < SEG_N; g++) begin : g_seg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
            psz_q[g] <= 2'd0;
         end else if (we && widx == SEG_IDX_W'(g)) begin
            vld_q[g] <= wvalid;
            psz_q[g] <= wpsz;
         end
      end
   end

   assign rvalid = vld_q[ridx];
   assign rpsz   = psz_q[ridx];

endmodule

// File: rtl/iox_addr_split.sv
module iox_addr_split #(
   parameter int SEG_OFF_W = 28,
   parameter int RA_W      = 32,
   localparam int VPN_W = SEG_OFF_W - 12,
   localparam int RPN_W = RA_W - 12
) (
   input  logic [SEG_OFF_W-1:0] seg_off,
   input  logic [1:0]           psz,
   input  logic [RPN_W-1:0]     rpn,
   output logic [VPN_W-1:0]     vpn,
   output logic [RA_W-1:0]      ra
);

   logic [4:0]      shamt;
   logic [RA_W-1:0] off_mask;
   logic [RA_W-1:0] frame;
   logic [RA_W-1:0] off_ext;

   // offset width grows by four bits per page-size step
   assign shamt = 5'd12 + {1'b0, psz, 2'b00};

   always_comb begin
      off_mask = (RA_W'(1) << shamt) - RA_W'(1);
      frame    = {rpn, 12'b0};
      off_ext  = RA_W'(seg_off);
      vpn      = VPN_W'(seg_off >> shamt);
      ra       = (frame & ~off_mask) | (off_ext & off_mask);
   end

endmodule

// File: rtl/iox_tcache.sv
module iox_tcache #(
   parameter int N         = 4,
   parameter int SEG_IDX_W = 4,
   parameter int VPN_W     = 16,
   parameter int RPN_W     = 20,
   parameter int DEV_W     = 4,
   parameter int ORD_W     = 2,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SEG_IDX_W-1:0] lk_seg,
   input  logic [VPN_W-1:0]     lk_vpn,
   output logic                 lk_hit,
   output logic [RPN_W-1:0]     lk_rpn,
   output logic                 lk_rd,
   output logic                 lk_wr,
   output logic [DEV_W-1:0]     lk_dev,
   output logic [ORD_W-1:0]     lk_ord,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [SEG_IDX_W-1:0] wr_seg,
   input  logic [VPN_W-1:0]     wr_vpn,
   input  logic [RPN_W-1:0]     wr_rpn,
   input  logic                 wr_rd,
   input  logic                 wr_wr,
   input  logic [DEV_W-1:0]     wr_dev,
   input  logic [ORD_W-1:0]     wr_ord,
   input  logic                 inval,
   output logic [N-1:0]         vld_vec
);

   logic                 vld_q [N];
   logic [SEG_IDX_W-1:0] seg_q [N];
   logic [VPN_W-1:0]     vpn_q [N];
   logic [RPN_W-1:0]     rpn_q [N];
   logic                 rd_q  [N];
   logic                 wr_q  [N];
   logic [DEV_W-1:0]     dev_q [N];
   logic [ORD_W-1:0]     ord_q [N];
   logic [N-1:0]         match;

   for (genvar g = 0; g < N; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
         end else if (inval) begin
            vld_q[g] <= 1'b0;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            vld_q[g] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && wr_idx == IDX_W'(g)) begin
            seg_q[g] <= wr_seg;
            vpn_q[g] <= wr_vpn;
            rpn_q[g] <= wr_rpn;
            rd_q[g]  <= wr_rd;
            wr_q[g]  <= wr_wr;
            dev_q[g] <= wr_dev;
            ord_q[g] <= wr_ord;
         end
      end
   end

   always_comb begin
      match  = '0;
      lk_rpn = '0;
      lk_rd  = 1'b0;
      lk_wr  = 1'b0;
      lk_dev = '0;
      lk_ord = '0;
      for (int i = 0; i < N; i++) begin
         vld_vec[i] = vld_q[i];
         match[i]   = vld_q[i] && seg_q[i] == lk_seg && vpn_q[i] == lk_vpn;
         if (match[i]) begin
            lk_rpn = lk_rpn | rpn_q[i];
            lk_rd  = lk_rd  | rd_q[i];
            lk_wr  = lk_wr  | wr_q[i];
            lk_dev = lk_dev | dev_q[i];
            lk_ord = lk_ord | ord_q[i];
         end
      end
      lk_hit = |match;
   end

endmodule

// File: rtl/io_xlate_unit.sv
module io_xlate_unit
   import iox_pkg::*;
#(
   parameter int IOA_W      = 32,
   parameter int SEG_OFF_W  = 28,
   parameter int RA_W       = 32,
   parameter int DEV_W      = 4,
   parameter int ORD_W      = 2,
   parameter int TC_ENTRIES = 4,
   localparam int SEG_IDX_W = IOA_W - SEG_OFF_W,
   localparam int VPN_W     = SEG_OFF_W - MIN_PAGE_W,
   localparam int RPN_W     = RA_W - MIN_PAGE_W,
   localparam int TC_IDX_W  = (TC_ENTRIES > 1) ? $clog2(TC_ENTRIES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_hw_load,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [IOA_W-1:0]     req_ioa,
   input  logic [DEV_W-1:0]     req_dev,
   input  logic                 req_wr,
   output logic                 rsp_valid,
   output logic                 rsp_ok,
   output logic [1:0]           rsp_fault,
   output logic [RA_W-1:0]      rsp_ra,
   output logic [ORD_W-1:0]     rsp_ord,
   output logic                 wlk_req_valid,
   output logic [SEG_IDX_W-1:0] wlk_req_seg,
   output logic [VPN_W-1:0]     wlk_req_vpn,
   input  logic                 wlk_rsp_valid,
   input  logic                 wlk_rsp_err,
   input  logic [RPN_W-1:0]     wlk_rsp_rpn,
   input  logic                 wlk_rsp_rd,
   input  logic                 wlk_rsp_wr,
   input  logic [DEV_W-1:0]     wlk_rsp_dev,
   input  logic [ORD_W-1:0]     wlk_rsp_ord,
   input  logic                 sw_seg_we,
   input  logic [SEG_IDX_W-1:0] sw_seg_idx,
   input  logic                 sw_seg_valid,
   input  logic [1:0]           sw_seg_psz,
   input  logic                 sw_tc_we,
   input  logic [TC_IDX_W-1:0]  sw_tc_idx,
   input  logic [SEG_IDX_W-1:0] sw_tc_seg,
   input  logic [VPN_W-1:0]     sw_tc_vpn,
   input  logic [RPN_W-1:0]     sw_tc_rpn,
   input  logic                 sw_tc_rd,
   input  logic                 sw_tc_wr,
   input  logic [DEV_W-1:0]     sw_tc_dev,
   input  logic [ORD_W-1:0]     sw_tc_ord,
   input  logic                 sw_inval,
   input  logic                 flt_clr,
   output logic                 flt_valid,
   output logic [IOA_W-1:0]     flt_ioa,
   output logic [DEV_W-1:0]     flt_dev
);

   // ---------------- elaboration checks ----------------
   if (SEG_OFF_W <= 24) begin : g_bad_segoff
      $error("SEG_OFF_W must exceed the largest page offset (24)");
   end
   if (SEG_OFF_W >= IOA_W) begin : g_bad_segidx
      $error("IOA_W must leave at least one segment index bit");
   end
   if (RA_W <= 24) begin : g_bad_ra
      $error("RA_W must exceed the largest page offset (24)");
   end
   if (TC_ENTRIES < 1) begin : g_bad_tc
      $error("TC_ENTRIES must be at least one");
   end

   // ---------------- address fields ----------------
   logic [SEG_IDX_W-1:0] lk_seg;
   logic [SEG_OFF_W-1:0] lk_off;
   logic                 seg_vld;
   logic [1:0]           seg_psz;
   logic [VPN_W-1:0]     lk_vpn;
   logic [RA_W-1:0]      xl_ra;

   assign lk_seg = req_ioa[IOA_W-1:SEG_OFF_W];
   assign lk_off = req_ioa[SEG_OFF_W-1:0];

   iox_seg_table #(.SEG_IDX_W(SEG_IDX_W)) u_seg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (sw_seg_we),
      .widx   (sw_seg_idx),
      .wvalid (sw_seg_valid),
      .wpsz   (sw_seg_psz),
      .ridx   (lk_seg),
      .rvalid (seg_vld),
      .rpsz   (seg_psz)
   );

   // ---------------- translation cache ----------------
   logic                 tc_hit;
   logic [RPN_W-1:0]     tc_rpn;
   logic                 tc_rd;
   logic                 tc_wr;
   logic [DEV_W-1:0]     tc_dev;
   logic [ORD_W-1:0]     tc_ord;
   logic [TC_ENTRIES-1:0] tc_vld;
   logic                 tc_we;
   logic [TC_IDX_W-1:0]  tc_widx;
   logic [SEG_IDX_W-1:0] tc_wseg;
   logic [VPN_W-1:0]     tc_wvpn;
   logic [RPN_W-1:0]     tc_wrpn;
   logic                 tc_wrd;
   logic                 tc_wwr;
   logic [DEV_W-1:0]     tc_wdev;
   logic [ORD_W-1:0]     tc_word;

   iox_tcache #(
      .N         (TC_ENTRIES),
      .SEG_IDX_W (SEG_IDX_W),
      .VPN_W     (VPN_W),
      .RPN_W     (RPN_W),
      .DEV_W     (DEV_W),
      .ORD_W     (ORD_W)
   ) u_tc (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_seg  (lk_seg),
      .lk_vpn  (lk_vpn),
      .lk_hit  (tc_hit),
      .lk_rpn  (tc_rpn),
      .lk_rd   (tc_rd),
      .lk_wr   (tc_wr),
      .lk_dev  (tc_dev),
      .lk_ord  (tc_ord),
      .wr_en   (tc_we),
      .wr_idx  (tc_widx),
      .wr_seg  (tc_wseg),
      .wr_vpn  (tc_wvpn),
      .wr_rpn  (tc_wrpn),
      .wr_rd   (tc_wrd),
      .wr_wr   (tc_wwr),
      .wr_dev  (tc_wdev),
      .wr_ord  (tc_word),
      .inval   (sw_inval),
      .vld_vec (tc_vld)
   );

   iox_addr_split #(.SEG_OFF_W(SEG_OFF_W), .RA_W(RA_W)) u_split (
      .seg_off (lk_off),
      .psz     (seg_psz),
      .rpn     (tc_rpn),
      .vpn     (lk_vpn),
      .ra      (xl_ra)
   );

   // ---------------- control ----------------
   iox_state_e           st_q, st_d;
   iox_flt_e             flt_code;
   logic                 accept;
   logic                 start_walk;
   logic                 fill_en;
   logic                 perm_ok;
   logic [SEG_IDX_W-1:0] wk_seg_q;
   logic [VPN_W-1:0]     wk_vpn_q;
   logic [TC_IDX_W-1:0]  rr_q;

   assign perm_ok = (req_wr ? tc_wr : tc_rd) && (tc_dev == req_dev);

   always_comb begin
      st_d       = st_q;
      accept     = 1'b0;
      flt_code   = FLT_NONE;
      start_walk = 1'b0;
      fill_en    = 1'b0;
      unique case (st_q)
         ST_LOOK: begin
            if (req_valid) begin
               if (!seg_vld) begin
                  accept   = 1'b1;
                  flt_code = FLT_XLATE;
               end else if (tc_hit) begin
                  accept = 1'b1;
                  if (!perm_ok) flt_code = FLT_PROT;
               end else if (cfg_hw_load) begin
                  start_walk = 1'b1;
                  st_d       = ST_FETCH;
               end else begin
                  accept   = 1'b1;
                  flt_code = FLT_XLATE;
               end
            end
         end
         ST_FETCH: st_d = ST_WAIT;
         ST_WAIT: begin
            if (wlk_rsp_valid) begin
               st_d = ST_LOOK;
               if (wlk_rsp_err) begin
                  accept   = req_valid;
                  flt_code = FLT_XLATE;
               end else begin
                  // a software write in the same cycle owns the port; the
                  // request misses again and re-walks
                  fill_en = !sw_tc_we;
               end
            end
         end
         default: st_d = ST_LOOK;
      endcase
   end

   assign req_ready     = accept;
   assign wlk_req_valid = (st_q == ST_FETCH);
   assign wlk_req_seg   = wk_seg_q;
   assign wlk_req_vpn   = wk_vpn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_LOOK;
         wk_seg_q <= '0;
         wk_vpn_q <= '0;
      end else begin
         st_q <= st_d;
         if (start_walk) begin
            wk_seg_q <= lk_seg;
            wk_vpn_q <= lk_vpn;
         end
      end
   end

   // ---------------- fill port and replacement ----------------
   if (TC_ENTRIES == 1) begin : g_rr_single
      assign rr_q = '0;
   end else begin : g_rr_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rr_q <= '0;
         end else if (fill_en) begin
            if (rr_q == TC_IDX_W'(TC_ENTRIES - 1)) rr_q <= '0;
            else                                   rr_q <= rr_q + 1'b1;
         end
      end
   end

   always_comb begin
      tc_we = sw_tc_we | fill_en;
      if (sw_tc_we) begin
         tc_widx = sw_tc_idx;
         tc_wseg = sw_tc_seg;
         tc_wvpn = sw_tc_vpn;
         tc_wrpn = sw_tc_rpn;
         tc_wrd  = sw_tc_rd;
         tc_wwr  = sw_tc_wr;
         tc_wdev = sw_tc_dev;
         tc_word = sw_tc_ord;
      end else begin
         tc_widx = rr_q;
         tc_wseg = wk_seg_q;
         tc_wvpn = wk_vpn_q;
         tc_wrpn = wlk_rsp_rpn;
         tc_wrd  = wlk_rsp_rd;
         tc_wwr  = wlk_rsp_wr;
         tc_wdev = wlk_rsp_dev;
         tc_word = wlk_rsp_ord;
      end
   end

   // ---------------- response and fault status ----------------
   logic rsp_good;
   assign rsp_good = (flt_code == FLT_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         rsp_fault <= 2'd0;
         rsp_ra    <= '0;
         rsp_ord   <= '0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_ok    <= rsp_good;
            rsp_fault <= flt_code;
            rsp_ra    <= rsp_good ? xl_ra  : '0;
            rsp_ord   <= rsp_good ? tc_ord : '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_valid <= 1'b0;
         flt_ioa   <= '0;
         flt_dev   <= '0;
      end else if (accept && flt_code == FLT_PROT) begin
         flt_valid <= 1'b1;
         flt_ioa   <= req_ioa;
         flt_dev   <= req_dev;
      end else if (flt_clr) begin
         flt_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/iox_unit_chk.sv
module iox_unit_chk #(
   parameter int RA_W = 32,
   parameter int N    = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_hw_load,
   input logic            req_valid,
   input logic            req_ready,
   input logic            rsp_valid,
   input logic            rsp_ok,
   input logic [1:0]      rsp_fault,
   input logic [RA_W-1:0] rsp_ra,
   input logic            wlk_req_valid,
   input logic            sw_inval,
   input logic            flt_valid,
   input logic [N-1:0]    tc_vld
);

   AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> rsp_valid); // R12
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !(req_valid && req_ready) |=> !rsp_valid); // R12
   AST_OK_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_ok != (rsp_fault != 2'd0))); // R3
   AST_DENY_ZERO_RA: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ok) |-> (rsp_ra == '0)); // R4
   AST_PROT_LOGGED: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fault == 2'd2) |-> flt_valid); // R6
   AST_WALK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wlk_req_valid |=> !wlk_req_valid); // R7
   AST_STALL_ON_WALK: assert property (@(posedge clk) disable iff (!rst_n) wlk_req_valid |-> !req_ready); // R7
   AST_WALK_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n) wlk_req_valid |-> $past(cfg_hw_load)); // R9
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) sw_inval |=> (tc_vld == '0)); // R11

endmodule

bind io_xlate_unit iox_unit_chk #(.RA_W(RA_W), .N(TC_ENTRIES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_hw_load   (cfg_hw_load),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_ok        (rsp_ok),
   .rsp_fault     (rsp_fault),
   .rsp_ra        (rsp_ra),
   .wlk_req_valid (wlk_req_valid),
   .sw_inval      (sw_inval),
   .flt_valid     (flt_valid),
   .tc_vld        (tc_vld)
);

// File: tb/io_xlate_unit_tb_top.sv
module io_xlate_unit_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_hw_load = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_ioa = '0;
   logic [3:0]  req_dev = '0;
   logic        req_wr = 1'b0;
   logic        rsp_valid;
   logic        rsp_ok;
   logic [1:0]  rsp_fault;
   logic [31:0] rsp_ra;
   logic [1:0]  rsp_ord;
   logic        wlk_req_valid;
   logic [3:0]  wlk_req_seg;
   logic [15:0] wlk_req_vpn;
   logic        wlk_rsp_valid = 1'b0;
   logic        wlk_rsp_err = 1'b0;
   logic [19:0] wlk_rsp_rpn = '0;
   logic        wlk_rsp_rd = 1'b0;
   logic        wlk_rsp_wr = 1'b0;
   logic [3:0]  wlk_rsp_dev = '0;
   logic [1:0]  wlk_rsp_ord = '0;
   logic        sw_seg_we = 1'b0;
   logic [3:0]  sw_seg_idx = '0;
   logic        sw_seg_valid = 1'b0;
   logic [1:0]  sw_seg_psz = '0;
   logic        sw_tc_we = 1'b0;
   logic [1:0]  sw_tc_idx = '0;
   logic [3:0]  sw_tc_seg = '0;
   logic [15:0] sw_tc_vpn = '0;
   logic [19:0] sw_tc_rpn = '0;
   logic        sw_tc_rd = 1'b0;
   logic        sw_tc_wr = 1'b0;
   logic [3:0]  sw_tc_dev = '0;
   logic [1:0]  sw_tc_ord = '0;
   logic        sw_inval = 1'b0;
   logic        flt_clr = 1'b0;
   logic        flt_valid;
   logic [31:0] flt_ioa;
   logic [3:0]  flt_dev;

   always #(CLK_PERIOD / 2) clk = ~clk;

   io_xlate_unit dut_i (.*);

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit good, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!good) begin
         n_err++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
      end
   endtask

   task automatic report();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   // ---------------- scoreboard ----------------
   typedef struct {
      logic        ok;
      logic [1:0]  flt;
      logic [31:0] ra;
      logic [1:0]  ord;
      string       rq;
   } exp_t;

   exp_t exp_q[$];
   exp_t mon_e;

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R12", "response without request", 64'(rsp_valid), 64'd0);
         end else begin
            mon_e = exp_q.pop_front();
            chk(rsp_ok === mon_e.ok, mon_e.rq, "rsp_ok", 64'(rsp_ok), 64'(mon_e.ok));
            chk(rsp_fault === mon_e.flt, mon_e.rq, "rsp_fault", 64'(rsp_fault), 64'(mon_e.flt));
            chk(rsp_ra === mon_e.ra, mon_e.rq, "rsp_ra", 64'(rsp_ra), 64'(mon_e.ra));
            chk(rsp_ord === mon_e.ord, mon_e.rq, "rsp_ord", 64'(rsp_ord), 64'(mon_e.ord));
         end
      end
   end

   // ---------------- walker model ----------------
   int          wk_cnt = 0;
   logic [3:0]  wk_seg_seen = '0;
   logic [15:0] wk_vpn_seen = '0;
   logic        wk_err = 1'b0;
   logic [19:0] wk_rpn = '0;
   logic        wk_rd = 1'b0;
   logic        wk_wr = 1'b0;
   logic [3:0]  wk_dev = '0;
   logic [1:0]  wk_ord = '0;

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && wlk_req_valid) begin
            wk_cnt++;
            wk_seg_seen = wlk_req_seg;
            wk_vpn_seen = wlk_req_vpn;
            repeat (3) @(negedge clk);
            wlk_rsp_valid = 1'b1;
            wlk_rsp_err   = wk_err;
            wlk_rsp_rpn   = wk_rpn;
            wlk_rsp_rd    = wk_rd;
            wlk_rsp_wr    = wk_wr;
            wlk_rsp_dev   = wk_dev;
            wlk_rsp_ord   = wk_ord;
            @(negedge clk);
            wlk_rsp_valid = 1'b0;
            wlk_rsp_err   = 1'b0;
         end
      end
   end

   // ---------------- driver tasks ----------------
   task automatic xact(input logic [31:0] ioa, input logic [3:0] dev, input logic wr,
                       input logic eok, input logic [1:0] eflt, input logic [31:0] era,
                       input logic [1:0] eord, input string rq, output int waited);
      exp_t e;
      e.ok = eok; e.flt = eflt; e.ra = era; e.ord = eord; e.rq = rq;
      exp_q.push_back(e);
      req_ioa   = ioa;
      req_dev   = dev;
      req_wr    = wr;
      req_valid = 1'b1;
      waited    = 0;
      forever begin
         #1;
         if (req_ready) break;
         @(negedge clk);
         waited++;
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic seg_wr(input logic [3:0] idx, input logic vld, input logic [1:0] psz);
      @(negedge clk);
      sw_seg_we = 1'b1; sw_seg_idx = idx; sw_seg_valid = vld; sw_seg_psz = psz;
      @(negedge clk);
      sw_seg_we = 1'b0;
   endtask

   task automatic tc_wr(input logic [1:0] idx, input logic [3:0] seg, input logic [15:0] vpn,
                        input logic [19:0] rpn, input logic rd, input logic wr,
                        input logic [3:0] dev, input logic [1:0] ord);
      @(negedge clk);
      sw_tc_we = 1'b1; sw_tc_idx = idx; sw_tc_seg = seg; sw_tc_vpn = vpn;
      sw_tc_rpn = rpn; sw_tc_rd = rd; sw_tc_wr = wr; sw_tc_dev = dev; sw_tc_ord = ord;
      @(negedge clk);
      sw_tc_we = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      report();
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(rsp_valid === 1'b0, "R12", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
      chk(wlk_req_valid === 1'b0, "R7", "wlk_req_valid after reset", 64'(wlk_req_valid), 64'd0);
      chk(flt_valid === 1'b0, "R6", "flt_valid after reset", 64'(flt_valid), 64'd0);

      // segments: 1=4K, 2=64K, 3=1M, 4=16M, 5 left invalid
      seg_wr(4'd1, 1'b1, 2'd0);
      seg_wr(4'd2, 1'b1, 2'd1);
      seg_wr(4'd3, 1'b1, 2'd2);
      seg_wr(4'd4, 1'b1, 2'd3);
      tc_wr(2'd0, 4'd1, 16'h0123, 20'hABCDE, 1'b1, 1'b1, 4'd3, 2'd1);
      tc_wr(2'd1, 4'd2, 16'h0034, 20'h12345, 1'b1, 1'b0, 4'd5, 2'd2);
      tc_wr(2'd2, 4'd3, 16'h000A, 20'h77777, 1'b0, 1'b1, 4'd2, 2'd3);
      tc_wr(2'd3, 4'd4, 16'h0005, 20'h9ABCD, 1'b1, 1'b1, 4'd0, 2'd0);

      // R2 / R3 per page size
      xact(32'h1012_3456, 4'd3, 1'b0, 1'b1, 2'd0, 32'hABCD_E456, 2'd1, "R2 4K page", w);
      xact(32'h2034_5678, 4'd5, 1'b0, 1'b1, 2'd0, 32'h1234_5678, 2'd2, "R3 64K page read", w);
      xact(32'h30AB_CDEF, 4'd2, 1'b1, 1'b1, 2'd0, 32'h777B_CDEF, 2'd3, "R2 1M page write", w);
      xact(32'h4512_3456, 4'd0, 1'b1, 1'b1, 2'd0, 32'h9A12_3456, 2'd0, "R2 16M page", w);
      drain();
      chk(flt_valid === 1'b0, "R6", "no record on success", 64'(flt_valid), 64'd0);

      // R4 write denied
      xact(32'h2034_5678, 4'd5, 1'b1, 1'b0, 2'd2, 32'h0, 2'd0, "R4 write denied", w);
      drain();
      chk(flt_valid === 1'b1, "R6", "flt_valid after write deny", 64'(flt_valid), 64'd1);
      chk(flt_ioa === 32'h2034_5678, "R6", "flt_ioa", 64'(flt_ioa), 64'h2034_5678);
      chk(flt_dev === 4'd5, "R6", "flt_dev", 64'(flt_dev), 64'd5);
      // R4 read denied
      xact(32'h30AB_CDEF, 4'd2, 1'b0, 1'b0, 2'd2, 32'h0, 2'd0, "R4 read denied", w);
      // R5 device mismatch
      xact(32'h2034_5678, 4'd6, 1'b0, 1'b0, 2'd2, 32'h0, 2'd0, "R5 device mismatch", w);
      drain();
      chk(flt_dev === 4'd6, "R6", "flt_dev overwritten", 64'(flt_dev), 64'd6);
      @(negedge clk); flt_clr = 1'b1; @(negedge clk); flt_clr = 1'b0; #1;
      chk(flt_valid === 1'b0, "R6", "flt_valid after clear", 64'(flt_valid), 64'd0);

      // R1 invalid segment, R9 miss without hardware load
      xact(32'h5000_0000, 4'd0, 1'b0, 1'b0, 2'd1, 32'h0, 2'd0, "R1 invalid segment", w);
      xact(32'h1099_9000, 4'd3, 1'b0, 1'b0, 2'd1, 32'h0, 2'd0, "R9 miss no load", w);
      drain();
      chk(wk_cnt == 0, "R9", "walker requests", 64'(wk_cnt), 64'd0);
      chk(flt_valid === 1'b0, "R6", "translation fault not recorded", 64'(flt_valid), 64'd0);

      // R10 software rewrite
      tc_wr(2'd0, 4'd1, 16'h0123, 20'h11111, 1'b1, 1'b1, 4'd3, 2'd1);
      xact(32'h1012_3456, 4'd3, 1'b0, 1'b1, 2'd0, 32'h1111_1456, 2'd1, "R10 rewritten entry", w);
      drain();

      // R11 flush
      @(negedge clk); sw_inval = 1'b1; @(negedge clk); sw_inval = 1'b0;
      xact(32'h1012_3456, 4'd3, 1'b0, 1'b0, 2'd1, 32'h0, 2'd0, "R11 miss after flush", w);
      xact(32'h4512_3456, 4'd0, 1'b0, 1'b0, 2'd1, 32'h0, 2'd0, "R11 miss after flush", w);
      drain();

      // R7 hardware load
      cfg_hw_load = 1'b1;
      wk_err = 1'b0; wk_rpn = 20'h55555; wk_rd = 1'b1; wk_wr = 1'b1; wk_dev = 4'd3; wk_ord = 2'd2;
      xact(32'h1012_3456, 4'd3, 1'b0, 1'b1, 2'd0, 32'h5555_5456, 2'd2, "R7 filled by walker", w);
      drain();
      chk(w >= 4, "R7", "stall cycles", 64'(w), 64'd4);
      chk(wk_cnt == 1, "R7", "walker requests", 64'(wk_cnt), 64'd1);
      chk(wk_seg_seen === 4'd1, "R7", "walker segment", 64'(wk_seg_seen), 64'd1);
      chk(wk_vpn_seen === 16'h0123, "R7", "walker page number", 64'(wk_vpn_seen), 64'h0123);
      xact(32'h1012_3ABC, 4'd3, 1'b1, 1'b1, 2'd0, 32'h5555_5ABC, 2'd2, "R7 hit after fill", w);
      drain();
      chk(w == 0, "R7", "no stall on hit", 64'(w), 64'd0);
      chk(wk_cnt == 1, "R7", "no second fetch", 64'(wk_cnt), 64'd1);

      // R8 walker error
      wk_err = 1'b1;
      xact(32'h2099_0000, 4'd0, 1'b0, 1'b0, 2'd1, 32'h0, 2'd0, "R8 walker error", w);
      drain();
      chk(wk_cnt == 2, "R8", "walker requests", 64'(wk_cnt), 64'd2);
      wk_err = 1'b0;
      // R1 invalid segment never walks
      xact(32'h5123_0000, 4'd0, 1'b0, 1'b0, 2'd1, 32'h0, 2'd0, "R1 invalid segment, load on", w);
      drain();
      chk(wk_cnt == 2, "R1", "no walk for invalid segment", 64'(wk_cnt), 64'd2);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R12", "responses outstanding", 64'(exp_q.size()), 64'd0);
      report();
      $finish;
   end

endmodule